// File: doc/BRIEF.md
# Buffered Memory Write Logger

This block sits beside the write port of main memory and copies every write it sees (address and data) into a sequential non-volatile log. The log can then rebuild memory state as of any checkpoint. Writes are not sent to the log directly. They land first in one of two staging banks, so the memory side only has to wait when the bank that takes new writes is full and cannot free a slot in the same cycle. The log port accepts one record per cycle while `log_ready` is high.

A checkpoint coordinator drives `ckpt_req`. When the block sees the request high, it drains every write taken before the request into the log, then raises `flush_done` and holds it until the request drops. After the request drops, the block writes one boundary record into the log. Writes that arrive while the checkpoint is open are steered into the second bank. They are logged after the boundary record and so count toward the next checkpoint. The two banks then swap roles.

Top module: `mwl_logger`

## Requirements
- R1: While reset is applied and directly after it, `log_wr`, `snoop_stall` and `flush_done` are low and `log_ptr` is 0.
- R2: Every accepted snoop write (`snoop_vld` high and `snoop_stall` low at a clock edge) produces exactly one log record with `log_kind` = 0 (data). The record carries the same address and data, and records appear in the order the writes were accepted.
- R3: With both banks empty, no checkpoint open and `log_ready` high, the record for a write accepted at one clock edge is presented on the log port in the cycle that follows that edge.
- R4: `log_wr` is only high while `log_ready` is high. While `log_ready` is low, `log_ptr` does not move and up to BANK_DEPTH writes are held per bank.
- R5: `snoop_stall` is high exactly when the bank taking new writes is full and no entry of that bank leaves in the same cycle. A write offered while `snoop_stall` is high is not taken.
- R6: After `ckpt_req` is seen high, every write accepted before that edge is written to the log before `flush_done` rises.
- R7: `flush_done` rises only once the pre-checkpoint writes are drained, and it stays high until `ckpt_req` is seen low. If nothing is buffered, it rises two clock edges after the request is first sampled high.
- R8: Writes accepted while a checkpoint is open are not logged before the boundary record. They follow it, in their order of acceptance.
- R9: One clock edge after `ckpt_req` is seen low following `flush_done`, one boundary record is presented (once `log_ready` allows). It has `log_kind` = 1, `log_addr` = 0, and `log_data` equal to the number of earlier boundary records (0 for the first).
- R10: `log_ptr` gives the slot of the record being written. It advances by one for each record written and wraps from LOG_DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snoop_vld | input | 1 | A memory write is present on the snoop inputs |
| snoop_addr | input | ADDR_W | Address of the snooped write |
| snoop_data | input | DATA_W | Data of the snooped write |
| snoop_stall | output | 1 | The offered write is not taken this cycle |
| ckpt_req | input | 1 | Checkpoint request level from the coordinator |
| flush_done | output | 1 | Pre-checkpoint writes are all in the log |
| log_ready | input | 1 | Log port can take a record this cycle |
| log_wr | output | 1 | A record is written this cycle |
| log_ptr | output | $clog2(LOG_DEPTH) | Log slot of the current record |
| log_kind | output | 1 | Record type: 0 data, 1 boundary |
| log_addr | output | ADDR_W | Record address field |
| log_data | output | DATA_W | Record data field, or checkpoint number for a boundary |

## Verification
Each result has a fixed due time:
- A data record is due in the cycle after the edge that accepts its write.
- `snoop_stall` is combinational on the current bank state and `log_ready`, so it is due in the same cycle as the stimulus.
- With empty banks, `flush_done` is due two edges after the request is sampled.
- A boundary record is due one edge after the request is sampled low.

The bench changes inputs 2 ns after a rising edge. It samples outputs on the falling edge of exactly the cycle those counts give. Ordering results are compared record by record against a list built from the writes that were accepted.

// File: rtl/mwl_pkg.sv
package mwl_pkg;

  // Controller phases
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,  // normal logging from the active bank
    ST_DRAIN = 2'd1,  // checkpoint open, emptying the active bank
    ST_HOLD  = 2'd2,  // drained, flush_done high, waiting for request to drop
    ST_MARK  = 2'd3   // emitting the boundary record
  } mwl_state_e;

  localparam logic KIND_DATA  = 1'b0;
  localparam logic KIND_BOUND = 1'b1;

endpackage

// File: rtl/mwl_rst_sync.sv
module mwl_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/mwl_bank.sv
module mwl_bank #(
  parameter int WIDTH = 96,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp_q, wp_d;
  logic [PW-1:0]    rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (push) begin
      wp_d = (wp_q == LAST) ? '0 : wp_q + PW'(1);
    end
    if (pop) begin
      rp_d = (rp_q == LAST) ? '0 : rp_q + PW'(1);
    end
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= wp_d;
      if (pop)  rp_q <= rp_d;
      if (push || pop) cnt_q <= cnt_d;
    end
  end

  // Storage needs no reset: only read once the count says valid
  always_ff @(posedge clk) begin
    if (push) begin
      mem[wp_q] <= din;
    end
  end

  assign dout  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  // R5: a bank never takes a write it has no room for
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  // R2: nothing is read out of an empty bank
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/mwl_log_ptr.sv
module mwl_log_ptr #(
  parameter int LOG_DEPTH = 65536
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         adv,
  output logic [$clog2(LOG_DEPTH)-1:0] ptr
);

  localparam int PW = $clog2(LOG_DEPTH);
  localparam logic [PW-1:0] LAST = PW'(LOG_DEPTH - 1);

  logic [PW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = (ptr_q == LAST) ? '0 : ptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

  // R10: the slot only moves when a record is written
  p_ptr_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));

  // R10: after the top slot the next record goes to slot 0
  p_ptr_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr == LAST) |=> (ptr == '0));

endmodule

// File: rtl/mwl_ctrl.sv
module mwl_ctrl
  import mwl_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ckpt_req,
  input  logic              log_ready,
  input  logic              snoop_vld,
  input  logic [1:0]        bank_empty,
  input  logic [1:0]        bank_full,
  output logic [1:0]        bank_push,
  output logic [1:0]        bank_pop,
  output logic              drain_sel,
  output logic              log_wr,
  output logic              log_kind,
  output logic              snoop_stall,
  output logic              flush_done,
  output logic [DATA_W-1:0] epoch
);

  mwl_state_e        state_q, state_d;
  logic              cur_q, cur_d;
  logic [DATA_W-1:0] epoch_q, epoch_d;

  logic tgt;
  logic drain_act;
  logic pop_ok;
  logic mark_ok;
  logic blocked;

  // Datapath steering
  always_comb begin
    tgt       = (state_q == ST_RUN) ? cur_q : ~cur_q;
    drain_act = ((state_q == ST_RUN) || (state_q == ST_DRAIN)) && !bank_empty[cur_q];
    pop_ok    = log_ready && drain_act;
    mark_ok   = log_ready && (state_q == ST_MARK);
    blocked   = bank_full[tgt] && !(pop_ok && (tgt == cur_q));

    bank_pop         = 2'b00;
    bank_pop[cur_q]  = pop_ok;
    bank_push        = 2'b00;
    bank_push[tgt]   = snoop_vld && !blocked;
  end

  // Next state
  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    epoch_d = epoch_q;
    unique case (state_q)
      ST_RUN: begin
        if (ckpt_req) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (bank_empty[cur_q]) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (!ckpt_req) state_d = ST_MARK;
      end
      ST_MARK: begin
        if (log_ready) begin
          state_d = ST_RUN;
          cur_d   = ~cur_q;
          epoch_d = epoch_q + DATA_W'(1);
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cur_q   <= 1'b0;
      epoch_q <= '0;
    end else begin
      state_q <= state_d;
      if (mark_ok) begin
        cur_q   <= cur_d;
        epoch_q <= epoch_d;
      end
    end
  end

  assign drain_sel   = cur_q;
  assign log_wr      = pop_ok || mark_ok;
  assign log_kind    = (state_q == ST_MARK) ? KIND_BOUND : KIND_DATA;
  assign snoop_stall = blocked;
  assign flush_done  = (state_q == ST_HOLD);
  assign epoch       = epoch_q;

  // R6: completion is only reported with the closing bank empty
  p_done_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> bank_empty[cur_q]);

  // R7: completion stays up while the request is still high
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_done && ckpt_req) |=> flush_done);

  // R5: a stall is only raised when some bank is full
  p_stall_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_stall |-> (bank_full != 2'b00));

  // R9: exactly one boundary record per checkpoint
  p_one_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (log_wr && log_kind) |=> !(log_wr && log_kind));

endmodule

// File: rtl/mwl_logger.sv
module mwl_logger #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int BANK_DEPTH = 8,
  parameter int LOG_DEPTH  = 65536
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         snoop_vld,
  input  logic [ADDR_W-1:0]            snoop_addr,
  input  logic [DATA_W-1:0]            snoop_data,
  output logic                         snoop_stall,
  input  logic                         ckpt_req,
  output logic                         flush_done,
  input  logic                         log_ready,
  output logic                         log_wr,
  output logic [$clog2(LOG_DEPTH)-1:0] log_ptr,
  output logic                         log_kind,
  output logic [ADDR_W-1:0]            log_addr,
  output logic [DATA_W-1:0]            log_data
);

  localparam int REC_W    = ADDR_W + DATA_W;
  localparam int NUM_BANK = 2;

  logic                rst_n_s;
  logic [1:0]          bank_push, bank_pop, bank_empty, bank_full;
  logic [REC_W-1:0]    bank_dout [NUM_BANK];
  logic [REC_W-1:0]    head_rec;
  logic                drain_sel;
  logic [DATA_W-1:0]   epoch;

  mwl_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    mwl_bank #(
      .WIDTH (REC_W),
      .DEPTH (BANK_DEPTH)
    ) i_bank (
      .clk   (clk),
      .rst_n (rst_n_s),
      .push  (bank_push[b]),
      .din   ({snoop_addr, snoop_data}),
      .pop   (bank_pop[b]),
      .dout  (bank_dout[b]),
      .empty (bank_empty[b]),
      .full  (bank_full[b])
    );
  end

  mwl_ctrl #(
    .DATA_W (DATA_W)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .ckpt_req    (ckpt_req),
    .log_ready   (log_ready),
    .snoop_vld   (snoop_vld),
    .bank_empty  (bank_empty),
    .bank_full   (bank_full),
    .bank_push   (bank_push),
    .bank_pop    (bank_pop),
    .drain_sel   (drain_sel),
    .log_wr      (log_wr),
    .log_kind    (log_kind),
    .snoop_stall (snoop_stall),
    .flush_done  (flush_done),
    .epoch       (epoch)
  );

  mwl_log_ptr #(
    .LOG_DEPTH (LOG_DEPTH)
  ) i_log_ptr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .adv   (log_wr),
    .ptr   (log_ptr)
  );

  // Record formatting: boundary records carry the checkpoint number
  always_comb begin
    head_rec = bank_dout[drain_sel];
    if (log_kind) begin
      log_addr = '0;
      log_data = epoch;
    end else begin
      log_addr = head_rec[REC_W-1:DATA_W];
      log_data = head_rec[DATA_W-1:0];
    end
  end

  // R4: the log slot does not move while the log port is busy
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !log_ready |=> $stable(log_ptr));

  // R9: boundary records carry a zero address field
  p_mark_addr_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (log_wr && log_kind) |-> (log_addr == '0));

  // R4: nothing is written while the log port is busy
  p_wr_ready_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    log_wr |-> log_ready);

endmodule

// File: tb/test_mwl_logger.sv
module test_mwl_logger;

  localparam int AW   = 8;
  localparam int DW   = 16;
  localparam int BD   = 4;
  localparam int LD   = 16;
  localparam int PW   = $clog2(LD);
  localparam int MAXR = 256;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          snoop_vld;
  logic [AW-1:0] snoop_addr;
  logic [DW-1:0] snoop_data;
  logic          snoop_stall;
  logic          ckpt_req;
  logic          flush_done;
  logic          log_ready;
  logic          log_wr;
  logic [PW-1:0] log_ptr;
  logic          log_kind;
  logic [AW-1:0] log_addr;
  logic [DW-1:0] log_data;

  int errors = 0;
  int checks = 0;

  // Observed and expected record streams
  logic          mon_kind [MAXR];
  logic [AW-1:0] mon_addr [MAXR];
  logic [DW-1:0] mon_data [MAXR];
  logic [PW-1:0] mon_ptr  [MAXR];
  int            n_mon = 0;
  logic          exp_kind [MAXR];
  logic [AW-1:0] exp_addr [MAXR];
  logic [DW-1:0] exp_data [MAXR];
  int            n_exp = 0;
  int            cmp_idx = 0;

  always #4 clk = ~clk;  // 125 MHz

  mwl_logger #(
    .ADDR_W     (AW),
    .DATA_W     (DW),
    .BANK_DEPTH (BD),
    .LOG_DEPTH  (LD)
  ) i_mwl_logger (
    .clk         (clk),
    .rst_n       (rst_n),
    .snoop_vld   (snoop_vld),
    .snoop_addr  (snoop_addr),
    .snoop_data  (snoop_data),
    .snoop_stall (snoop_stall),
    .ckpt_req    (ckpt_req),
    .flush_done  (flush_done),
    .log_ready   (log_ready),
    .log_wr      (log_wr),
    .log_ptr     (log_ptr),
    .log_kind    (log_kind),
    .log_addr    (log_addr),
    .log_data    (log_data)
  );

  // A record visible at the falling edge is committed at the next rising edge
  always @(negedge clk) begin
    if (log_wr && n_mon < MAXR) begin
      mon_kind[n_mon] = log_kind;
      mon_addr[n_mon] = log_addr;
      mon_data[n_mon] = log_data;
      mon_ptr[n_mon]  = log_ptr;
      n_mon = n_mon + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push_exp(input logic k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_kind[n_exp] = k;
    exp_addr[n_exp] = a;
    exp_data[n_exp] = d;
    n_exp++;
  endtask

  // Offer one write and hold it until taken; optionally expect it next in the log
  task automatic write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit add);
    @(posedge clk); #2;
    snoop_vld  = 1'b1;
    snoop_addr = a;
    snoop_data = d;
    forever begin
      @(negedge clk);
      if (!snoop_stall) break;
    end
    @(posedge clk); #2;
    snoop_vld = 1'b0;
    if (add) push_exp(1'b0, a, d);
  endtask

  task automatic settle_and_compare(input string req);
    repeat (4 * BD + 12) @(negedge clk);
    chk(n_mon == n_exp, req, "record count", n_mon, n_exp);
    for (int i = cmp_idx; i < n_exp && i < n_mon; i++) begin
      chk(mon_kind[i] == exp_kind[i], req, "record kind", mon_kind[i], exp_kind[i]);
      chk(mon_addr[i] == exp_addr[i], req, "record addr", mon_addr[i], exp_addr[i]);
      chk(mon_data[i] == exp_data[i], req, "record data", mon_data[i], exp_data[i]);
    end
    cmp_idx = n_exp;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(log_wr == 1'b0,      "R1", "log_wr after reset", log_wr, 0);
    chk(snoop_stall == 1'b0, "R1", "stall after reset", snoop_stall, 0);
    chk(flush_done == 1'b0,  "R1", "flush_done after reset", flush_done, 0);
    chk(log_ptr == '0,       "R1", "log_ptr after reset", log_ptr, 0);
  endtask

  task automatic t_latency;
    log_ready = 1'b1;
    @(posedge clk); #2;
    snoop_vld = 1'b1; snoop_addr = 8'h11; snoop_data = 16'hA001;
    @(posedge clk); #2;           // accepted at this edge
    snoop_vld = 1'b0;
    push_exp(1'b0, 8'h11, 16'hA001);
    @(negedge clk);
    chk(log_wr == 1'b1,     "R3", "record one cycle after accept", log_wr, 1);
    chk(log_addr == 8'h11,  "R3", "record address", log_addr, 8'h11);
    chk(log_data == 16'hA001, "R3", "record data", log_data, 16'hA001);
    settle_and_compare("R2");
  endtask

  task automatic t_backpressure;
    log_ready = 1'b0;
    for (int i = 0; i < BD; i++) write(AW'(8'h20 + i), DW'(16'hB000 + i), 1'b1);
    @(posedge clk); #2;
    snoop_vld = 1'b1; snoop_addr = 8'h2F; snoop_data = 16'hB0FF;
    @(negedge clk);
    chk(snoop_stall == 1'b1, "R5", "stall with full bank and busy log", snoop_stall, 1);
    chk(log_wr == 1'b0,      "R4", "no write while log busy", log_wr, 0);
    @(posedge clk); #2;
    @(negedge clk);
    chk(snoop_stall == 1'b1, "R5", "stall held", snoop_stall, 1);
    @(posedge clk); #2;
    log_ready = 1'b1;
    @(negedge clk);
    chk(snoop_stall == 1'b0, "R5", "stall drops when an entry leaves", snoop_stall, 0);
    @(posedge clk); #2;
    snoop_vld = 1'b0;
    push_exp(1'b0, 8'h2F, 16'hB0FF);
    settle_and_compare("R2");
  endtask

  task automatic t_checkpoint;
    int waited;
    log_ready = 1'b0;
    for (int i = 0; i < 3; i++) write(AW'(8'h30 + i), DW'(16'hC000 + i), 1'b1);
    @(posedge clk); #2;
    ckpt_req = 1'b1;
    write(8'h40, 16'hD000, 1'b0);
    write(8'h41, 16'hD001, 1'b0);
    @(negedge clk);
    chk(flush_done == 1'b0, "R6", "no flush_done before drain", flush_done, 0);
    @(posedge clk); #2;
    log_ready = 1'b1;
    waited = 0;
    while (!flush_done && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    chk(flush_done == 1'b1, "R7", "flush_done after drain", flush_done, 1);
    chk(n_mon == cmp_idx + 3, "R6", "pre-checkpoint records logged", n_mon, cmp_idx + 3);
    write(8'h42, 16'hD002, 1'b0);
    write(8'h43, 16'hD003, 1'b0);
    @(posedge clk); #2;
    snoop_vld = 1'b1; snoop_addr = 8'h4F; snoop_data = 16'hDEAD;
    @(negedge clk);
    chk(snoop_stall == 1'b1, "R5", "stall with second bank full", snoop_stall, 1);
    chk(flush_done == 1'b1,  "R7", "flush_done held with request high", flush_done, 1);
    chk(log_wr == 1'b0,      "R8", "open-checkpoint writes not yet logged", log_wr, 0);
    @(posedge clk); #2;
    snoop_vld = 1'b0;
    ckpt_req  = 1'b0;
    push_exp(1'b1, '0, DW'(0));
    for (int i = 0; i < 4; i++) push_exp(1'b0, AW'(8'h40 + i), DW'(16'hD000 + i));
    settle_and_compare("R8");
  endtask

  task automatic t_empty_ckpt;
    log_ready = 1'b1;
    @(posedge clk); #2;
    ckpt_req = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(flush_done == 1'b0, "R7", "flush_done one edge after request", flush_done, 0);
    @(posedge clk); @(negedge clk);
    chk(flush_done == 1'b1, "R7", "flush_done two edges after request", flush_done, 1);
    @(posedge clk); #2;
    ckpt_req = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(log_wr && log_kind, "R9", "boundary record presented", {log_wr, log_kind}, 2'b11);
    chk(log_data == DW'(1), "R9", "boundary checkpoint number", log_data, 1);
    push_exp(1'b1, '0, DW'(1));
    settle_and_compare("R9");
  endtask

  task automatic t_wrap;
    log_ready = 1'b1;
    for (int i = 0; i < 4; i++) write(AW'(8'h50 + i), DW'(16'hE000 + i), 1'b1);
    settle_and_compare("R2");
    for (int i = 0; i < n_mon; i++) begin
      chk(mon_ptr[i] == PW'(i % LD), "R10", "log slot of record", mon_ptr[i], i % LD);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    snoop_vld  = 1'b0;
    snoop_addr = '0;
    snoop_data = '0;
    ckpt_req   = 1'b0;
    log_ready  = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_latency();
    t_backpressure();
    t_checkpoint();
    t_empty_ckpt();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule